// File: doc/BRIEF.md
# Bit Test and Masked Modify Unit

This block carries out the bit-test family of an accumulator-based processor: a plain test, a test that clears the bits selected by the accumulator in a memory operand, and a test that sets them. The caller presents the accumulator, the operand value that was already fetched, the target address, an operation code, an immediate-addressing indicator and a width flag on one cycle with `start_i` high. The unit updates its zero, negative and overflow flags on the clock edge that accepts the request.

For the two modify operations the unit then writes the merged value back through a byte-wide memory port. It raises a request, holds the address and data until the memory acknowledges, and steps to the next byte when the width is 16 bits. A one-cycle `done_o` pulse tells the caller that the operation is finished. While a write-back is in progress the unit is busy and ignores new requests.

Top module: `bitop_unit`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, and on the cycle after it, the zero, negative and overflow flags, `done_o`, `busy_o` and `mem_req_o` are all 0. This also holds when reset arrives in the middle of a write-back.
- R2: For every operation, the zero flag becomes 1 when the AND of the accumulator and the operand is zero over the active width, and 0 otherwise. The active width is the low 8 bits when `wide_i`=0 and all 16 bits when `wide_i`=1.
- R3: A plain test (op 00) with `imm_i`=0 loads the negative flag from the operand's top bit and the overflow flag from the bit below it. These are bits 7 and 6 when `wide_i`=0, and bits 15 and 14 when `wide_i`=1.
- R4: A plain test with `imm_i`=1 leaves the negative and overflow flags unchanged.
- R5: The modify operations (op 01 clear-bits, op 10 set-bits) leave the negative and overflow flags unchanged, whatever the value of `imm_i`. The zero flag is computed from the operand value before modification.
- R6: Clear-bits (op 01) writes back the operand ANDed with the complement of the accumulator.
- R7: Set-bits (op 10) writes back the operand ORed with the accumulator.
- R8: With `wide_i`=0 a modify operation performs exactly one byte write, at the given address. The high bytes of the accumulator and the operand then affect neither the flags nor the written data.
- R9: With `wide_i`=1 a modify operation writes the low result byte at the given address and then the high byte at address+1. Each write holds its request, address and data steady until `mem_ack_i` is 1 at a clock edge.
- R10: `done_o` is 1 for exactly one cycle. For a plain test this is the cycle after the accepting edge. For a modify operation it is the cycle after the edge where the last write is acknowledged.
- R11: A `start_i` raised while `busy_o` is 1 is ignored. It changes no flag and adds no write.
- R12: Op code 11 behaves exactly like a plain test (op 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when not busy |
| op_i | input | 2 | 00 test, 01 clear-bits, 10 set-bits, 11 test |
| imm_i | input | 1 | Operand came from immediate addressing |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| acc_i | input | 16 | Accumulator value |
| opnd_i | input | 16 | Operand value as read |
| addr_i | input | 16 | Operand address for write-back |
| busy_o | output | 1 | Write-back in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |
| mem_req_o | output | 1 | Byte write request |
| mem_addr_o | output | 16 | Write address |
| mem_wdata_o | output | 8 | Write data byte |
| mem_ack_i | input | 1 | Write acknowledge |

## Verification
The hardest situation to reach is a new request arriving while a 16-bit write-back is stalled by the memory. To exercise it, the bench's memory model withholds its acknowledge for a chosen number of cycles. During that stall the bench holds `start_i` high with a request that would change the overflow flag. It then confirms that the flags keep their values and that exactly two writes come out. The same stall is used to apply reset in the middle of a write-back.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
// Shared types for the bit test and modify unit.
// Assumes a two-bit operation code driven by the instruction decoder.
package bitop_pkg;

    typedef enum logic [1:0] {
        OP_TEST     = 2'b00,
        OP_CLRBITS  = 2'b01,
        OP_SETBITS  = 2'b10,
        OP_TEST_ALT = 2'b11
    } bitop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WR_LO = 2'b01,
        ST_WR_HI = 2'b10
    } seq_e;

    // True for the two operations that write memory back
    function automatic logic is_modify(bitop_e op);
        return (op == OP_CLRBITS) || (op == OP_SETBITS);
    endfunction

endpackage

// File: rtl/bitop_flags.sv
`timescale 1ns/1ps
// Computes the next zero, negative and overflow flag values.
// Assumes the operand is the value before any modification; purely combinational.
module bitop_flags
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  bitop_e              op_i,
    input  logic                imm_i,
    input  logic                wide_i,
    input  logic [2*BYTE_W-1:0] acc_i,
    input  logic [2*BYTE_W-1:0] opnd_i,
    input  logic                n_cur_i,
    input  logic                v_cur_i,
    output logic                z_nx_o,
    output logic                n_nx_o,
    output logic                v_nx_o
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_and;
    logic [BYTE_W-1:0] hi_and;
    logic              top_bit;
    logic              sub_bit;
    logic              load_nv;

    // Masked AND per byte and zero detection over the active width
    always_comb begin
        lo_and = acc_i[BYTE_W-1:0] & opnd_i[BYTE_W-1:0];
        hi_and = acc_i[WORD_W-1:BYTE_W] & opnd_i[WORD_W-1:BYTE_W];
        z_nx_o = (lo_and == '0) && (!wide_i || (hi_and == '0));
    end

    // Negative and overflow load only for a non-immediate plain test
    always_comb begin
        top_bit = wide_i ? opnd_i[WORD_W-1] : opnd_i[BYTE_W-1];
        sub_bit = wide_i ? opnd_i[WORD_W-2] : opnd_i[BYTE_W-2];
        load_nv = !is_modify(op_i) && !imm_i;
        n_nx_o  = load_nv ? top_bit : n_cur_i;
        v_nx_o  = load_nv ? sub_bit : v_cur_i;
    end

endmodule

// File: rtl/bitop_merge.sv
`timescale 1ns/1ps
// Forms the write-back word: clears or sets the operand bits selected by
// the accumulator. Assumes only clear-bits and set-bits results are used.
module bitop_merge
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  bitop_e              op_i,
    input  logic [2*BYTE_W-1:0] acc_i,
    input  logic [2*BYTE_W-1:0] opnd_i,
    output logic [2*BYTE_W-1:0] result_o
);
    // Select AND-NOT for clear-bits, OR otherwise
    always_comb begin
        if (op_i == OP_CLRBITS) begin
            result_o = opnd_i & ~acc_i;
        end else begin
            result_o = opnd_i | acc_i;
        end
    end

endmodule

// File: rtl/bitop_seq.sv
`timescale 1ns/1ps
// Sequencer: accepts requests when idle, drives one or two byte writes with a
// request/acknowledge handshake, and pulses done. Assumes the memory holds
// mem_ack_i for at most the cycle it accepts a byte.
module bitop_seq
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                modify_i,
    input  logic                wide_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [2*BYTE_W-1:0] result_i,
    input  logic                mem_ack_i,
    output logic                accept_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [BYTE_W-1:0]   mem_wdata_o
);
    localparam int WORD_W = 2 * BYTE_W;

    seq_e              state_q;
    logic              wide_q;
    logic              done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] res_q;

    assign accept_o = start_i && (state_q == ST_IDLE);

    // State, captured operands and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        if (modify_i) begin
                            state_q <= ST_WR_LO;
                            wide_q  <= wide_i;
                            addr_q  <= addr_i;
                            res_q   <= result_i;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_WR_LO: begin
                    if (mem_ack_i) begin
                        if (wide_q) begin
                            state_q <= ST_WR_HI;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_WR_HI: begin
                    if (mem_ack_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive from the current state
    always_comb begin
        mem_req_o   = (state_q != ST_IDLE);
        mem_addr_o  = (state_q == ST_WR_HI) ? addr_q + ADDR_W'(1) : addr_q;
        mem_wdata_o = (state_q == ST_WR_HI) ? res_q[WORD_W-1:BYTE_W]
                                            : res_q[BYTE_W-1:0];
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;

endmodule

// File: rtl/bitop_unit.sv
`timescale 1ns/1ps
// Top of the bit test and modify unit: flag registers, flag logic, merge
// logic and the write-back sequencer. Assumes the caller has already read
// the operand and supplies its address for the write-back.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic                imm_i,
    input  logic                wide_i,
    input  logic [2*BYTE_W-1:0] acc_i,
    input  logic [2*BYTE_W-1:0] opnd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                flag_z_o,
    output logic                flag_n_o,
    output logic                flag_v_o,
    output logic                mem_req_o,
    output logic [ADDR_W-1:0]   mem_addr_o,
    output logic [BYTE_W-1:0]   mem_wdata_o,
    input  logic                mem_ack_i
);
    localparam int WORD_W = 2 * BYTE_W;

    bitop_e            op;
    logic              accept;
    logic              z_nx;
    logic              n_nx;
    logic              v_nx;
    logic [WORD_W-1:0] result;
    logic              z_q;
    logic              n_q;
    logic              v_q;

    assign op = bitop_e'(op_i);

    bitop_flags #(.BYTE_W(BYTE_W)) u_flags (
        .op_i    (op),
        .imm_i   (imm_i),
        .wide_i  (wide_i),
        .acc_i   (acc_i),
        .opnd_i  (opnd_i),
        .n_cur_i (n_q),
        .v_cur_i (v_q),
        .z_nx_o  (z_nx),
        .n_nx_o  (n_nx),
        .v_nx_o  (v_nx)
    );

    bitop_merge #(.BYTE_W(BYTE_W)) u_merge (
        .op_i     (op),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .result_o (result)
    );

    bitop_seq #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .modify_i    (is_modify(op)),
        .wide_i      (wide_i),
        .addr_i      (addr_i),
        .result_i    (result),
        .mem_ack_i   (mem_ack_i),
        .accept_o    (accept),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    // Flag registers load on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            n_q <= 1'b0;
            v_q <= 1'b0;
        end else if (accept) begin
            z_q <= z_nx;
            n_q <= n_nx;
            v_q <= v_nx;
        end
    end

    assign flag_z_o = z_q;
    assign flag_n_o = n_q;
    assign flag_v_o = v_q;

endmodule

// File: rtl/bitop_unit_chk.sv
`timescale 1ns/1ps
// Protocol and flag checks for bitop_unit, attached by bind.
// Assumes it observes only the ports of the top module.
module bitop_unit_chk #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic              imm_i,
    input logic              wide_i,
    input logic              opnd_msb8,
    input logic              busy_o,
    input logic              done_o,
    input logic              flag_z_o,
    input logic              flag_n_o,
    input logic              flag_v_o,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [BYTE_W-1:0] mem_wdata_o,
    input logic              mem_ack_i
);
    // R9
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
        (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    busy_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable({flag_z_o, flag_n_o, flag_v_o}));

    // R4
    imm_test_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 2'b00 || op_i == 2'b11) && imm_i) |=>
        $stable({flag_n_o, flag_v_o}));

    // R5
    modify_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i == 2'b01 || op_i == 2'b10)) |=>
        ($stable({flag_n_o, flag_v_o}) && busy_o));

    // R3
    narrow_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == 2'b00 && !imm_i && !wide_i) |=>
        (flag_n_o == $past(opnd_msb8)));

endmodule

bind bitop_unit bitop_unit_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .imm_i       (imm_i),
    .wide_i      (wide_i),
    .opnd_msb8   (opnd_i[BYTE_W-1]),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .flag_z_o    (flag_z_o),
    .flag_n_o    (flag_n_o),
    .flag_v_o    (flag_v_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i)
);

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic        imm_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [15:0] acc_i = '0;
    logic [15:0] opnd_i = '0;
    logic [15:0] addr_i = '0;
    logic        busy_o, done_o, flag_z_o, flag_n_o, flag_v_o, mem_req_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic        mem_ack_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .imm_i(imm_i), .wide_i(wide_i), .acc_i(acc_i), .opnd_i(opnd_i),
        .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o),
        .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
    );

    // Fields: op[54:53] imm[52] wide[51] acc[50:35] opnd[34:19]
    //         exp z[18] n[17] v[16] exp written word[15:0]
    localparam logic [54:0] VECS [0:8] = '{
        {2'b00, 1'b0, 1'b0, 16'hFF01, 16'h12C2, 1'b1, 1'b1, 1'b1, 16'h0000},
        {2'b00, 1'b1, 1'b0, 16'h0003, 16'h0041, 1'b0, 1'b1, 1'b1, 16'h0000},
        {2'b00, 1'b0, 1'b1, 16'h8000, 16'h4000, 1'b1, 1'b0, 1'b1, 16'h0000},
        {2'b00, 1'b0, 1'b1, 16'h0100, 16'h8100, 1'b0, 1'b1, 1'b0, 16'h0000},
        {2'b01, 1'b0, 1'b0, 16'h000F, 16'hAB3C, 1'b0, 1'b1, 1'b0, 16'h0030},
        {2'b10, 1'b1, 1'b1, 16'h0F0F, 16'hF000, 1'b1, 1'b1, 1'b0, 16'hFF0F},
        {2'b01, 1'b0, 1'b1, 16'h00FF, 16'h12F0, 1'b0, 1'b1, 1'b0, 16'h1200},
        {2'b10, 1'b0, 1'b0, 16'hFF00, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000},
        {2'b11, 1'b0, 1'b0, 16'h0080, 16'h0080, 1'b0, 1'b1, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Issue one request and serve its writes; poke raises start while busy
    task automatic run_op(input logic [1:0] op, input logic imm, input logic wide,
                          input logic [15:0] acc, input logic [15:0] opnd,
                          input logic [15:0] addr, input int stall, input bit poke,
                          input logic ez, input logic en, input logic ev,
                          input logic [15:0] ewr);
        string nv_req;
        string wr_req;
        bit ismod;
        int nwr;
        int cnt;
        logic [15:0] wa [0:3];
        logic [7:0]  wd [0:3];
        ismod = (op == 2'b01) || (op == 2'b10);
        nv_req = ismod ? "R5" : (imm ? "R4" : (op == 2'b11 ? "R12" : "R3"));
        wr_req = (op == 2'b01) ? "R6" : "R7";
        @(negedge clk);
        op_i = op; imm_i = imm; wide_i = wide; acc_i = acc; opnd_i = opnd;
        addr_i = addr; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check("R2", "zero flag", {15'd0, flag_z_o}, {15'd0, ez});
        check(nv_req, "negative flag", {15'd0, flag_n_o}, {15'd0, en});
        check(nv_req, "overflow flag", {15'd0, flag_v_o}, {15'd0, ev});
        if (!ismod) begin
            check(op == 2'b11 ? "R12" : "R10", "done after test", {15'd0, done_o}, 16'd1);
            check("R10", "no write for test", {15'd0, mem_req_o}, 16'd0);
            @(posedge clk); #1;
            check("R10", "done drops", {15'd0, done_o}, 16'd0);
        end else begin
            check("R10", "no early done", {15'd0, done_o}, 16'd0);
            nwr = 0;
            cnt = 0;
            for (int g = 0; g < 40 && busy_o; g++) begin
                @(negedge clk);
                if (poke) begin
                    start_i = 1'b1; op_i = 2'b00; imm_i = 1'b0; wide_i = 1'b1;
                    acc_i = 16'hFFFF; opnd_i = 16'hFFFF;
                end
                mem_ack_i = (cnt >= stall);
                if (mem_req_o && mem_ack_i) begin
                    if (nwr < 4) begin wa[nwr] = mem_addr_o; wd[nwr] = mem_wdata_o; end
                    nwr++;
                    cnt = 0;
                end else begin
                    cnt++;
                end
                @(posedge clk); #1;
            end
            start_i = 1'b0;
            mem_ack_i = 1'b0;
            check("R10", "done after last write", {15'd0, done_o}, 16'd1);
            check(wide ? "R9" : "R8", "write count", 16'(nwr), wide ? 16'd2 : 16'd1);
            if (nwr >= 1) begin
                check(wide ? "R9" : "R8", "first write address", wa[0], addr);
                check(wr_req, "low byte data", {8'd0, wd[0]}, {8'd0, ewr[7:0]});
            end
            if (wide && nwr >= 2) begin
                check("R9", "second write address", wa[1], addr + 16'd1);
                check(wr_req, "high byte data", {8'd0, wd[1]}, {8'd0, ewr[15:8]});
            end
            if (poke) begin
                check("R11", "flags kept while busy",
                      {13'd0, flag_z_o, flag_n_o, flag_v_o}, {13'd0, ez, en, ev});
            end
            @(posedge clk); #1;
            check("R10", "done drops", {15'd0, done_o}, 16'd0);
            check("R11", "no extra write", {15'd0, mem_req_o}, 16'd0);
        end
    endtask

    task automatic check_reset_state(input string what);
        check("R1", what,
              {11'd0, flag_z_o, flag_n_o, flag_v_o, done_o, mem_req_o}, 16'd0);
        check("R1", {what, " busy"}, {15'd0, busy_o}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_reset_state("after reset");

        for (int i = 0; i < 9; i++) begin
            run_op(VECS[i][54:53], VECS[i][52], VECS[i][51], VECS[i][50:35],
                   VECS[i][34:19], 16'h1000 + 16'(i * 16), i % 3, 1'b0,
                   VECS[i][18], VECS[i][17], VECS[i][16], VECS[i][15:0]);
        end

        // R11: set-bits, 16-bit, stalled memory, start held during busy
        run_op(2'b10, 1'b0, 1'b1, 16'h0001, 16'h00F1, 16'h2FFF, 3, 1'b1,
               1'b0, 1'b1, 1'b0, 16'h00F1);

        // R8: 8-bit clear-bits, high bytes would change result if used
        run_op(2'b01, 1'b0, 1'b0, 16'hFF81, 16'h00FF, 16'h4000, 0, 1'b0,
               1'b0, 1'b1, 1'b0, 16'h007E);

        // R1: reset in the middle of a stalled write-back
        @(negedge clk);
        op_i = 2'b01; imm_i = 1'b0; wide_i = 1'b1; acc_i = 16'h0001;
        opnd_i = 16'h8001; addr_i = 16'h5000; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check("R1", "busy before mid-op reset", {15'd0, busy_o}, 16'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_reset_state("mid-op reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_reset_state("after mid-op reset");

        finish_run();
    end

endmodule